// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block frees a two-wire serial bus that a slave device has left stuck partway through a transfer. It runs a fixed recovery sequence. First it clocks the bus nine times while leaving the data line undriven, so that any slave still shifting out a byte can finish and let go of the data line. It then forms a STOP condition and leaves both lines released. Both lines are modelled as open-drain: the block only ever pulls a line low, and a logic 1 on the bus comes from the pull-up.

All timing is expressed in delay units. One unit is a programmable number of system clock cycles, taken from the divider input when a sequence begins. A sequence starts on its own after reset, as part of bring-up, and again whenever a start pulse arrives while the block is idle. When the final release has finished, a one-cycle completion pulse is raised. At the same moment the block records whether both lines actually read high, which tells the caller whether the bus came free.

Top module: `i2c_bus_recover`

## Requirements
- R1: While reset (rstN low) is asserted, neither line is pulled low, busy is 0, done is 0 and lineIdle is 0.
- R2: With AUTO_START set (the default), a sequence begins at the first clock edge after reset is released, without any start pulse.
- R3: A start pulse sampled high while idle begins a sequence. From the next cycle busy is 1 and SCL is pulled low.
- R4: The sequence opens with exactly 9 clock pulses. Each pulse pulls SCL low for 2 units and then releases it for 2 units, and SDA is never pulled low during the pulses.
- R5: After the pulses comes the STOP. It has four steps of 1 unit each: SCL low with SDA released, then both low, then SCL released with SDA low, then both released.
- R6: One unit is tickDiv cycles, with a tickDiv of 0 treated as 1. The value is latched when the sequence starts, and later changes to tickDiv have no effect on the running sequence.
- R7: A start pulse that arrives while busy is 1 is ignored: the running sequence keeps its timing and no second sequence follows it.
- R8: A sequence lasts exactly 40 units. In the cycle after the last unit, busy is 0 and done is 1, and done is 1 for that cycle only.
- R9: lineIdle takes the value (sclIn AND sdaIn) sampled at the end of the last unit, and holds it until the next sequence completes.
- R10: When idle, neither line is pulled low. SDA is pulled low only while SCL is already pulled low, and SDA is released only while SCL is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | Request to run the recovery sequence |
| tickDiv | input | DIV_W | System cycles per delay unit (0 acts as 1) |
| sclIn | input | 1 | Level read back from the clock line |
| sdaIn | input | 1 | Level read back from the data line |
| sclDriveLow | output | 1 | Pulls the clock line low when 1 |
| sdaDriveLow | output | 1 | Pulls the data line low when 1 |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when the sequence finishes |
| lineIdle | output | 1 | Both lines read high at the end of the last sequence |

## Verification
Every sequence is compared cycle by cycle against a waveform the bench computes from the unit length. Any error in a half-period, the pulse count or the order of the STOP steps therefore shows up in the exact cycle where it occurs. Unit lengths of 0, 1 and several random values separate the divider-of-zero case from off-by-one errors in counting units. Start pulses and divider changes injected in the middle of a run tell a latched configuration apart from a live one. A slave model that keeps holding SDA low tells a genuine line readback apart from an idle flag that is simply set at the end of every sequence.

// File: rtl/i2c_bus_recover_pkg.sv
package i2c_bus_recover_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOW, ST_HIGH, ST_STOPA, ST_STOPB, ST_STOPC, ST_STOPD
  } recState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // latch divider, clear counters
    logic run;        // advance the unit timer
    logic longStage;  // current stage spans two units
    logic nextPulse;  // one more pulse finished
    logic capture;    // sample the line levels
  } dpStrobe_t;
endpackage

// File: rtl/i2c_bus_recover_dp.sv
module i2c_bus_recover_dp
  import i2c_bus_recover_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int PULSES = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [DIV_W-1:0] tickDiv,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             stageEnd,
  output logic             lastPulse,
  output logic             lineIdle
);
  localparam int PCNT_W = $clog2(PULSES + 1);
  localparam logic [PCNT_W-1:0] LAST_P = PCNT_W'(PULSES - 1);

  logic [DIV_W-1:0]  divQ;
  logic [DIV_W-1:0]  cycCnt;
  logic              unitIdx;
  logic [PCNT_W-1:0] pulseCnt;
  logic              unitTick;

  assign unitTick  = strb.run && (cycCnt == divQ - DIV_W'(1));
  assign stageEnd  = unitTick && (unitIdx == strb.longStage);
  assign lastPulse = (pulseCnt == LAST_P);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ     <= DIV_W'(1);
      cycCnt   <= '0;
      unitIdx  <= 1'b0;
      pulseCnt <= '0;
      lineIdle <= 1'b0;
    end else begin
      if (strb.load) begin
        divQ     <= (tickDiv == '0) ? DIV_W'(1) : tickDiv;
        cycCnt   <= '0;
        unitIdx  <= 1'b0;
        pulseCnt <= '0;
      end else if (strb.run) begin
        if (unitTick) begin
          cycCnt  <= '0;
          unitIdx <= stageEnd ? 1'b0 : ~unitIdx;
        end else begin
          cycCnt <= cycCnt + DIV_W'(1);
        end
        if (strb.nextPulse) pulseCnt <= pulseCnt + PCNT_W'(1);
      end
      if (strb.capture) lineIdle <= sclIn & sdaIn;
    end
  end
endmodule

// File: rtl/i2c_bus_recover_ctrl.sv
module i2c_bus_recover_ctrl
  import i2c_bus_recover_pkg::*;
#(
  parameter bit AUTO_START = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      stageEnd,
  input  logic      lastPulse,
  output dpStrobe_t strb,
  output logic      sclDriveLow,
  output logic      sdaDriveLow,
  output logic      busy,
  output logic      done
);
  recState_t state, stateNext;
  logic autoPend;
  logic go;

  assign go = (startPulse || autoPend) && (state == ST_IDLE);

  always_comb begin
    strb.load      = go;
    strb.run       = (state != ST_IDLE);
    strb.longStage = (state == ST_LOW) || (state == ST_HIGH);
    strb.nextPulse = (state == ST_HIGH) && stageEnd && !lastPulse;
    strb.capture   = (state == ST_STOPD) && stageEnd;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (go) stateNext = ST_LOW;
      ST_LOW:   if (stageEnd) stateNext = ST_HIGH;
      ST_HIGH:  if (stageEnd) stateNext = lastPulse ? ST_STOPA : ST_LOW;
      ST_STOPA: if (stageEnd) stateNext = ST_STOPB;
      ST_STOPB: if (stageEnd) stateNext = ST_STOPC;
      ST_STOPC: if (stageEnd) stateNext = ST_STOPD;
      ST_STOPD: if (stageEnd) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      autoPend <= AUTO_START;
      done     <= 1'b0;
    end else begin
      state <= stateNext;
      if (go) autoPend <= 1'b0;
      done <= (state == ST_STOPD) && stageEnd;
    end
  end

  assign sclDriveLow = (state == ST_LOW) || (state == ST_STOPA) || (state == ST_STOPB);
  assign sdaDriveLow = (state == ST_STOPB) || (state == ST_STOPC);
  assign busy        = (state != ST_IDLE);
endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover
  import i2c_bus_recover_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int PULSES     = 9,
  parameter bit AUTO_START = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [DIV_W-1:0] tickDiv,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sclDriveLow,
  output logic             sdaDriveLow,
  output logic             busy,
  output logic             done,
  output logic             lineIdle
);
  dpStrobe_t strb;
  logic stageEnd;
  logic lastPulse;

  i2c_bus_recover_ctrl #(.AUTO_START(AUTO_START)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .stageEnd(stageEnd), .lastPulse(lastPulse), .strb(strb),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .busy(busy), .done(done)
  );

  i2c_bus_recover_dp #(.DIV_W(DIV_W), .PULSES(PULSES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .tickDiv(tickDiv),
    .sclIn(sclIn), .sdaIn(sdaIn), .stageEnd(stageEnd),
    .lastPulse(lastPulse), .lineIdle(lineIdle)
  );
endmodule

// File: rtl/i2c_bus_recover_chk.sv
module i2c_bus_recover_chk (
  input logic clk,
  input logic rstN,
  input logic sclDriveLow,
  input logic sdaDriveLow,
  input logic busy,
  input logic done
);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R8
  done_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclDriveLow && !sdaDriveLow));
  // R10
  sda_pull_under_scl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> (sclDriveLow && $past(sclDriveLow)));
  // R5
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaDriveLow) |-> !sclDriveLow);
endmodule

bind i2c_bus_recover i2c_bus_recover_chk u_chk (
  .clk(clk), .rstN(rstN), .sclDriveLow(sclDriveLow),
  .sdaDriveLow(sdaDriveLow), .busy(busy), .done(done)
);

// File: tb/i2c_bus_recover_tb.sv
module i2c_bus_recover_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [15:0] tickDiv = 16'd2;
  logic        slaveHold = 1'b0;
  logic        sclIn, sdaIn;
  logic        sclDriveLow, sdaDriveLow, busy, done, lineIdle;
  int          nRun = 0;
  int          nFail = 0;
  int          cyc = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  assign sclIn = ~sclDriveLow;
  assign sdaIn = ~sdaDriveLow & ~slaveHold;

  i2c_bus_recover u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .tickDiv(tickDiv),
    .sclIn(sclIn), .sdaIn(sdaIn), .sclDriveLow(sclDriveLow),
    .sdaDriveLow(sdaDriveLow), .busy(busy), .done(done), .lineIdle(lineIdle)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      nFail = nFail + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun = nRun + 1;
    if (!ok) begin
      nFail = nFail + 1;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // expected waveform; k counts cycles after the accepting edge
  function automatic bit expScl(int k, int d);
    int u = (k - 1) / d;
    if (k < 1 || u >= 40) return 1'b0;
    if (u < 36) return (u % 4) < 2;
    return (u == 36) || (u == 37);
  endfunction

  function automatic bit expSda(int k, int d);
    int u = (k - 1) / d;
    if (k < 1 || u >= 40) return 1'b0;
    return (u == 37) || (u == 38);
  endfunction

  // called at the negedge right after the accepting edge
  task automatic checkRun(input int divIn, input bit hold, input int ignoreAt,
                          input int chgAt, input string tag);
    int d = (divIn == 0) ? 1 : divIn;
    int last = 40 * d;
    for (int k = 1; k <= last + 2; k++) begin
      chk(sclDriveLow == expScl(k, d), {tag, " R4 R5 scl"}, sclDriveLow, expScl(k, d));
      chk(sdaDriveLow == expSda(k, d), {tag, " R4 R5 sda"}, sdaDriveLow, expSda(k, d));
      chk(busy == (k <= last), {tag, " R8 busy"}, busy, (k <= last));
      chk(done == (k == last + 1), {tag, " R8 done"}, done, (k == last + 1));
      if (k > last)
        chk(lineIdle == !hold, {tag, " R9 lineIdle"}, lineIdle, !hold);
      startPulse = (k == ignoreAt);
      if (k == chgAt) tickDiv = tickDiv + 16'd3;
      @(negedge clk);
    end
    startPulse = 1'b0;
    chk(!busy, {tag, " R7 no rerun"}, busy, 0);
  endtask

  task automatic kick(input int divIn, input bit hold, input int ignoreAt,
                      input int chgAt, input string tag);
    tickDiv   = 16'(divIn);
    slaveHold = hold;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    checkRun(divIn, hold, ignoreAt, chgAt, tag);
  endtask

  initial begin
    void'($urandom(32'd4711));
    tickDiv = 16'd2;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!sclDriveLow && !sdaDriveLow, "R1 lines", sclDriveLow + sdaDriveLow, 0);
    chk(!busy && !done, "R1 busy/done", busy + done, 0);
    chk(!lineIdle, "R1 lineIdle", lineIdle, 0);
    // R2 automatic run after reset release
    rstN = 1'b1;
    @(negedge clk);
    checkRun(2, 1'b0, 0, 0, "R2 auto");
    repeat (4) @(negedge clk);
    chk(!busy, "R3 idle without request", busy, 0);
    // R3 R6 directed: divider 0 and 1, R9 held SDA, R7 start mid-run
    kick(0, 1'b0, 0, 0, "R3 R6 div0");
    kick(1, 1'b0, 17, 0, "R7 div1");
    kick(3, 1'b1, 0, 50, "R9 hold R6");
    repeat (5) @(negedge clk);
    chk(!lineIdle, "R9 held value", lineIdle, 0);
    kick(1, 1'b0, 39, 0, "R7 late");
    // random runs
    for (int i = 0; i < 12; i++) begin
      int dv = $urandom % 7;
      int dd = (dv == 0) ? 1 : dv;
      int ig = 1 + ($urandom % (40 * dd - 1));
      int cg = 1 + ($urandom % (40 * dd));
      bit hd = ($urandom % 4) == 0;
      kick(dv, hd, ig, cg, "R6 R7 rand");
      repeat ($urandom % 3) @(negedge clk);
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule